// File: doc/BRIEF.md
# Single-Level GPU Address Translation Unit

This block maps 32-bit virtual addresses issued by a graphics engine onto bus physical addresses. Translation goes through one flat table kept in memory. Each 32-bit entry describes one 4 KB page. The entry holds a 24-bit frame number in its low bits and three flag bits above it: valid at bit 28, write-permitted at bit 29, and 1 MB superpage at bit 31. Recent entries are held in an eight-slot, fully associative translation cache that is refilled in round-robin order.

On a cache miss the block reads one entry from the table base plus four times the virtual page index, over a simple request/response read port. Only one read is outstanding at a time. The request is held on a valid/ready handshake until the translation is complete. The block flags two kinds of fault: an entry that is not valid, and a write through an entry that is not writeable. Each fault kind has its own abort enable and interrupt enable. A faulting access can optionally be steered to a configured scratch page. A pulse on the clear input empties the cache, and a busy flag stays high while the clear is running.

Top module: `gpu_xlate_mmu`

## Requirements
- R1: For a valid 4 KB entry, the physical address is {entry[23:0], vaddr[11:0]}, giving 36 bits.
- R2: On a miss, the block issues one read at address {cfg_pt_base, 12'h000} + 4 * vaddr[31:12]. The read holds valid and address stable until ready is seen, and no new request is accepted while it is outstanding.
- R3: An entry with bit 31 set is a 1 MB superpage and gives {entry[23:8], vaddr[19:0]}. Once such an entry is cached, any address in the same megabyte (the same vaddr[31:20]) hits it.
- R4: An entry with bit 28 clear marks a fault on the result. xl_abort follows cfg_inv_abort_en, and irq_invalid pulses with the result when cfg_inv_irq_en is set.
- R5: A write through a valid entry with bit 29 clear marks a fault. xl_abort follows cfg_wr_abort_en, and irq_write pulses when cfg_wr_irq_en is set. A read through the same entry does not fault.
- R6: While cfg_scratch_en is set, a faulting access returns {cfg_scratch_frame, vaddr[11:0]}. Non-faulting accesses are never redirected.
- R7: A cache hit issues no table read, and the result appears two clock edges after the accepting edge.
- R8: The cache holds 8 entries and is refilled in round-robin order from slot 0 after reset or a clear. The ninth distinct page fetched evicts the oldest one.
- R9: A clear pulse holds tlb_clearing high for exactly 8 cycles, starting at the next edge. A pulse while it is high is ignored. Afterwards every earlier page misses.
- R10: A lookup waits while a clear is running and completes after it ends. An entry returned after a clear began is used for its result but is not cached.
- R11: Entries with bit 28 clear are never cached, so every access to such a page reads the table again.
- R12: After reset, req_ready is high and all outputs are low. req_ready is high only when idle. xl_valid lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pt_base | input | 24 | Table base address shifted right by 12 |
| cfg_inv_abort_en | input | 1 | Abort on an invalid entry |
| cfg_inv_irq_en | input | 1 | Interrupt on an invalid entry |
| cfg_wr_abort_en | input | 1 | Abort on a write violation |
| cfg_wr_irq_en | input | 1 | Interrupt on a write violation |
| cfg_scratch_en | input | 1 | Redirect faulting accesses to the scratch page |
| cfg_scratch_frame | input | 24 | Scratch page frame number |
| tlb_clear | input | 1 | Pulse that starts a cache clear |
| tlb_clearing | output | 1 | High while a clear is running |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| xl_valid | output | 1 | Result pulse |
| xl_paddr | output | 36 | Translated physical address |
| xl_fault | output | 1 | Access faulted |
| xl_abort | output | 1 | Access must be aborted |
| irq_invalid | output | 1 | Invalid-entry interrupt pulse |
| irq_write | output | 1 | Write-violation interrupt pulse |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Table read accepted |
| mem_rd_addr | output | 36 | Table entry byte address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table entry |

## Verification
The properties assume three things about the environment. The memory side returns exactly one response for each accepted read and none otherwise. The configuration inputs stay constant while a translation is in flight. A request is held stable until it is accepted. The bench's memory responder answers each read once, after a settable latency. The bench changes configuration only between transactions and holds each request unchanged until req_ready has been seen.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int PTE_FRAME_W = 24;
  localparam int PTE_W       = 32;

  // entry layout: bit 31 superpage, bit 30 spare, bit 29 writeable, bit 28 valid
  typedef struct packed {
    logic                   sp;
    logic                   spare;
    logic                   wr;
    logic                   vld;
    logic [3:0]             rsvd;
    logic [PTE_FRAME_W-1:0] frame;
  } pte_t;

  function automatic pte_t to_pte(input logic [PTE_W-1:0] raw);
    return pte_t'(raw);
  endfunction
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int SP_SPAN = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output pte_t             hit_pte,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  pte_t             ins_pte,
  input  logic             clr_start,
  output logic             clearing
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0] slot_v;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   slot_tag [ENTRIES];
  pte_t               slot_pte [ENTRIES];
  logic [IDX_W-1:0]   rr;
  logic [CNT_W-1:0]   clr_cnt;

  assign clearing = (clr_cnt != '0);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match[g] = slot_v[g] &&
      (slot_pte[g].sp ? (slot_tag[g][VPN_W-1:SP_SPAN] == look_vpn[VPN_W-1:SP_SPAN])
                      : (slot_tag[g] == look_vpn));
  end

  always_comb begin
    hit_pte = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_pte = slot_pte[i];
  end
  assign hit = |match;

  // clear walks one slot per cycle, top slot first
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v  <= '0;
      rr      <= '0;
      clr_cnt <= '0;
    end else if (clearing) begin
      slot_v[IDX_W'(clr_cnt - 1'b1)] <= 1'b0;
      clr_cnt <= clr_cnt - 1'b1;
    end else if (clr_start) begin
      clr_cnt <= CNT_W'(ENTRIES);
      rr      <= '0;
    end else if (ins_en) begin
      slot_v[rr] <= 1'b1;
      rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en && !clearing && !clr_start) begin
      slot_tag[rr] <= ins_vpn;
      slot_pte[rr] <= ins_pte;
    end
  end
endmodule

// File: rtl/xlate_fault.sv
module xlate_fault
  import xlate_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int SP_SHIFT   = 20,
  parameter int PA_W       = PTE_FRAME_W + PAGE_SHIFT
)(
  input  pte_t                   pte,
  input  logic [SP_SHIFT-1:0]    va_low,
  input  logic                   is_write,
  input  logic                   inv_abort_en,
  input  logic                   inv_irq_en,
  input  logic                   wr_abort_en,
  input  logic                   wr_irq_en,
  input  logic                   scratch_en,
  input  logic [PTE_FRAME_W-1:0] scratch_frame,
  output logic [PA_W-1:0]        paddr,
  output logic                   fault,
  output logic                   abort,
  output logic                   irq_inv,
  output logic                   irq_wr
);
  localparam int SP_SPAN = SP_SHIFT - PAGE_SHIFT;

  logic inv, wv;
  assign inv     = !pte.vld;
  assign wv      = pte.vld && is_write && !pte.wr;
  assign fault   = inv || wv;
  assign abort   = (inv && inv_abort_en) || (wv && wr_abort_en);
  assign irq_inv = inv && inv_irq_en;
  assign irq_wr  = wv && wr_irq_en;

  always_comb begin
    if (fault && scratch_en)
      paddr = {scratch_frame, va_low[PAGE_SHIFT-1:0]};
    else if (pte.sp && pte.vld)
      paddr = {pte.frame[PTE_FRAME_W-1:SP_SPAN], va_low};
    else
      paddr = {pte.frame, va_low[PAGE_SHIFT-1:0]};
  end
endmodule

// File: rtl/gpu_xlate_mmu.sv
module gpu_xlate_mmu
  import xlate_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int SP_SHIFT    = 20,
  parameter int TLB_ENTRIES = 8,
  parameter int PA_W        = PTE_FRAME_W + PAGE_SHIFT
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PTE_FRAME_W-1:0] cfg_pt_base,
  input  logic                   cfg_inv_abort_en,
  input  logic                   cfg_inv_irq_en,
  input  logic                   cfg_wr_abort_en,
  input  logic                   cfg_wr_irq_en,
  input  logic                   cfg_scratch_en,
  input  logic [PTE_FRAME_W-1:0] cfg_scratch_frame,
  input  logic                   tlb_clear,
  output logic                   tlb_clearing,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  output logic                   xl_valid,
  output logic [PA_W-1:0]        xl_paddr,
  output logic                   xl_fault,
  output logic                   xl_abort,
  output logic                   irq_invalid,
  output logic                   irq_write,
  output logic                   mem_rd_valid,
  input  logic                   mem_rd_ready,
  output logic [PA_W-1:0]        mem_rd_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PTE_W-1:0]       mem_rsp_data
);
  localparam int VPN_W   = VA_W - PAGE_SHIFT;
  localparam int SP_SPAN = SP_SHIFT - PAGE_SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FETCH, S_WAIT} st_t;

  st_t             state;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic            stale_q;

  logic            tlb_hit;
  pte_t            tlb_pte;
  pte_t            rsp_pte;
  pte_t            sel_pte;
  logic            look_go;
  logic            done;
  logic            ins_en;
  logic [PA_W-1:0] fetch_addr;
  logic [PA_W-1:0] f_paddr;
  logic            f_fault, f_abort, f_irq_inv, f_irq_wr;

  assign req_ready    = (state == S_IDLE);
  assign mem_rd_valid = (state == S_FETCH);
  assign rsp_pte      = to_pte(mem_rsp_data);
  assign sel_pte      = (state == S_WAIT) ? rsp_pte : tlb_pte;
  assign look_go      = (state == S_LOOK) && !tlb_clearing && !tlb_clear;
  assign done         = (look_go && tlb_hit) || ((state == S_WAIT) && mem_rsp_valid);
  assign ins_en       = (state == S_WAIT) && mem_rsp_valid && rsp_pte.vld &&
                        !stale_q && !tlb_clear && !tlb_clearing;
  assign fetch_addr   = {cfg_pt_base, {PAGE_SHIFT{1'b0}}} +
                        PA_W'({va_q[VA_W-1:PAGE_SHIFT], 2'b00});

  xlate_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (VPN_W),
    .SP_SPAN (SP_SPAN)
  ) u_tlb (
    .clk       (clk),
    .rst       (rst),
    .look_vpn  (va_q[VA_W-1:PAGE_SHIFT]),
    .hit       (tlb_hit),
    .hit_pte   (tlb_pte),
    .ins_en    (ins_en),
    .ins_vpn   (va_q[VA_W-1:PAGE_SHIFT]),
    .ins_pte   (rsp_pte),
    .clr_start (tlb_clear),
    .clearing  (tlb_clearing)
  );

  xlate_fault #(
    .PAGE_SHIFT (PAGE_SHIFT),
    .SP_SHIFT   (SP_SHIFT),
    .PA_W       (PA_W)
  ) u_fault (
    .pte           (sel_pte),
    .va_low        (va_q[SP_SHIFT-1:0]),
    .is_write      (wr_q),
    .inv_abort_en  (cfg_inv_abort_en),
    .inv_irq_en    (cfg_inv_irq_en),
    .wr_abort_en   (cfg_wr_abort_en),
    .wr_irq_en     (cfg_wr_irq_en),
    .scratch_en    (cfg_scratch_en),
    .scratch_frame (cfg_scratch_frame),
    .paddr         (f_paddr),
    .fault         (f_fault),
    .abort         (f_abort),
    .irq_inv       (f_irq_inv),
    .irq_wr        (f_irq_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      stale_q     <= 1'b0;
      mem_rd_addr <= '0;
      xl_valid    <= 1'b0;
      xl_paddr    <= '0;
      xl_fault    <= 1'b0;
      xl_abort    <= 1'b0;
      irq_invalid <= 1'b0;
      irq_write   <= 1'b0;
    end else begin
      xl_valid    <= done;
      irq_invalid <= done && f_irq_inv;
      irq_write   <= done && f_irq_wr;
      if (done) begin
        xl_paddr <= f_paddr;
        xl_fault <= f_fault;
        xl_abort <= f_abort;
      end
      unique case (state)
        S_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          state <= S_LOOK;
        end
        S_LOOK: if (look_go) begin
          if (tlb_hit) begin
            state <= S_IDLE;
          end else begin
            mem_rd_addr <= fetch_addr;
            stale_q     <= 1'b0;
            state       <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (tlb_clear) stale_q <= 1'b1;
          if (mem_rd_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (tlb_clear) stale_q <= 1'b1;
          if (mem_rsp_valid) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gpu_xlate_mmu_chk.sv
module gpu_xlate_mmu_chk #(
  parameter int PA_W        = 36,
  parameter int PAGE_SHIFT  = 12,
  parameter int FRAME_W     = 24
)(
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               tlb_clear,
  input logic               tlb_clearing,
  input logic               xl_valid,
  input logic               xl_fault,
  input logic               xl_abort,
  input logic [PA_W-1:0]    xl_paddr,
  input logic               irq_invalid,
  input logic               irq_write,
  input logic               mem_rd_valid,
  input logic               mem_rd_ready,
  input logic [PA_W-1:0]    mem_rd_addr,
  input logic               mem_rsp_valid,
  input logic               cfg_scratch_en,
  input logic [FRAME_W-1:0] cfg_scratch_frame
);
  p_accept_drops_ready_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_result_single_r12: assert property (@(posedge clk) disable iff (rst)
    xl_valid |=> !xl_valid);

  p_fetch_held_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  p_irq_with_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_invalid || irq_write) |-> (xl_valid && xl_fault));

  p_abort_needs_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && xl_abort) |-> xl_fault);

  p_scratch_redirect_r6: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && xl_fault && $past(cfg_scratch_en)) |->
      (xl_paddr[PA_W-1:PAGE_SHIFT] == $past(cfg_scratch_frame)));

  p_clear_starts_r9: assert property (@(posedge clk) disable iff (rst)
    (tlb_clear && !tlb_clearing) |=> tlb_clearing);

  p_stall_in_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (tlb_clearing && !mem_rsp_valid) |=> !xl_valid);
endmodule

bind gpu_xlate_mmu gpu_xlate_mmu_chk #(
  .PA_W       (PA_W),
  .PAGE_SHIFT (PAGE_SHIFT),
  .FRAME_W    (xlate_pkg::PTE_FRAME_W)
) u_chk (.*);

// File: tb/gpu_xlate_mmu_test.sv
`timescale 1ns/1ps
module gpu_xlate_mmu_test;
  localparam int PA_W = 36;
  localparam logic [31:0] F_VLD = 32'h1000_0000;
  localparam logic [31:0] F_WR  = 32'h2000_0000;
  localparam logic [31:0] F_SP  = 32'h8000_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [23:0] cfg_pt_base = 24'h000100;
  logic cfg_inv_abort_en = 0, cfg_inv_irq_en = 0, cfg_wr_abort_en = 0, cfg_wr_irq_en = 0;
  logic cfg_scratch_en = 0;
  logic [23:0] cfg_scratch_frame = 24'h0DEAD;
  logic tlb_clear = 0, tlb_clearing;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_vaddr = '0;
  logic xl_valid, xl_fault, xl_abort, irq_invalid, irq_write;
  logic [PA_W-1:0] xl_paddr, mem_rd_addr;
  logic mem_rd_valid, mem_rd_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  gpu_xlate_mmu uut (
    .clk(clk), .rst(rst), .cfg_pt_base(cfg_pt_base),
    .cfg_inv_abort_en(cfg_inv_abort_en), .cfg_inv_irq_en(cfg_inv_irq_en),
    .cfg_wr_abort_en(cfg_wr_abort_en), .cfg_wr_irq_en(cfg_wr_irq_en),
    .cfg_scratch_en(cfg_scratch_en), .cfg_scratch_frame(cfg_scratch_frame),
    .tlb_clear(tlb_clear), .tlb_clearing(tlb_clearing),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .xl_valid(xl_valid), .xl_paddr(xl_paddr), .xl_fault(xl_fault), .xl_abort(xl_abort),
    .irq_invalid(irq_invalid), .irq_write(irq_write),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int compared = 0, mismatched = 0;
  logic [31:0] pt [logic [19:0]];
  int fetches = 0;
  logic [PA_W-1:0] last_fetch = '0;
  int lat = 2;
  bit clr_after_fetch = 0;
  int clr_model = 0;
  logic [19:0] mtag [$];
  bit          msp  [$];

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] ptget(input logic [19:0] v);
    return pt.exists(v) ? pt[v] : 32'h0;
  endfunction

  function automatic bit m_hit(input logic [19:0] v);
    foreach (mtag[i])
      if (msp[i] ? (mtag[i][19:8] == v[19:8]) : (mtag[i] == v)) return 1'b1;
    return 1'b0;
  endfunction

  // busy-flag model, compared every clock (R9)
  always @(posedge clk) begin
    if (rst) clr_model = 0;
    else if (tlb_clear && clr_model == 0) begin clr_model = 8; clr_after_fetch = 1; end
    else if (clr_model > 0) clr_model--;
  end
  always @(negedge clk)
    if (!rst) check("R9 clearing flag", 64'(tlb_clearing), 64'(clr_model > 0));

  // table memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_rd_valid) begin
        mem_rd_ready = 1'b1;
        last_fetch = mem_rd_addr;
        clr_after_fetch = 0;
        fetches++;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        repeat (lat - 1) @(negedge clk);
        mem_rsp_data = ptget(20'((last_fetch - {cfg_pt_base, 12'h000}) >> 2));
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic pulse_clear();
    @(negedge clk);
    tlb_clear = 1'b1;
    mtag.delete(); msp.delete();
    @(negedge clk);
    tlb_clear = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input bit wr, input string tag, output int k);
    logic [19:0] vpn;
    logic [31:0] pte;
    bit exp_hit, inv, wv, flt, eab;
    logic [PA_W-1:0] ep;
    int f0;
    vpn = va[31:12];
    pte = ptget(vpn);
    exp_hit = m_hit(vpn);
    inv = !pte[28];
    wv  = !inv && wr && !pte[29];
    flt = inv || wv;
    if (flt && cfg_scratch_en) ep = {cfg_scratch_frame, va[11:0]};
    else if (pte[31] && !inv)  ep = {pte[23:8], va[19:0]};
    else                       ep = {pte[23:0], va[11:0]};
    eab = (inv && cfg_inv_abort_en) || (wv && cfg_wr_abort_en);
    f0 = fetches;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    while (!xl_valid && k < 400) begin @(negedge clk); k++; end
    check({tag, " result valid"}, 64'(xl_valid), 64'd1);
    check({tag, " paddr"}, 64'(xl_paddr), 64'(ep));
    check({tag, " fault R4 R5"}, 64'(xl_fault), 64'(flt));
    check({tag, " abort R4 R5"}, 64'(xl_abort), 64'(eab));
    check({tag, " irq_invalid R4"}, 64'(irq_invalid), 64'(inv && cfg_inv_irq_en));
    check({tag, " irq_write R5"}, 64'(irq_write), 64'(wv && cfg_wr_irq_en));
    check({tag, " table reads R7 R8 R11"}, 64'(fetches - f0), exp_hit ? 64'd0 : 64'd1);
    if (exp_hit) check({tag, " hit latency R7"}, 64'(k), 64'd2);
    else check({tag, " fetch address R2"}, 64'(last_fetch),
               64'({cfg_pt_base, 12'h000} + PA_W'({vpn, 2'b00})));
    if (!exp_hit && !inv && !clr_after_fetch) begin
      mtag.push_back(vpn); msp.push_back(pte[31]);
      if (mtag.size() > 8) begin void'(mtag.pop_front()); void'(msp.pop_front()); end
    end
    @(negedge clk);
    check({tag, " single pulse R12"}, 64'(xl_valid), 64'd0);
  endtask

  initial begin
    int k, f;
    repeat (4) @(negedge clk);
    check("R12 reset ready", 64'(req_ready), 64'd1);
    check("R12 reset xl_valid", 64'(xl_valid), 64'd0);
    check("R12 reset mem_rd_valid", 64'(mem_rd_valid), 64'd0);
    check("R12 reset clearing", 64'(tlb_clearing), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    pt[20'h12345] = F_VLD | F_WR | 32'h000ABCD;
    xlate(32'h1234_5678, 0, "R1 miss", k);
    xlate(32'h1234_5ABC, 1, "R7 hit", k);

    pt[20'h00200] = F_VLD | 32'h0000555;
    cfg_wr_abort_en = 1; cfg_wr_irq_en = 1;
    xlate(32'h0020_0010, 0, "R5 read ok", k);
    xlate(32'h0020_0020, 1, "R5 write viol", k);
    cfg_wr_abort_en = 0;
    xlate(32'h0020_0030, 1, "R5 irq only", k);

    cfg_inv_abort_en = 1;
    xlate(32'h0030_0004, 0, "R4 invalid abort", k);
    cfg_inv_abort_en = 0; cfg_inv_irq_en = 1;
    xlate(32'h0030_0008, 0, "R11 invalid refetch", k);

    cfg_scratch_en = 1;
    xlate(32'h0030_000C, 0, "R6 invalid redirect", k);
    xlate(32'h0020_0FFF, 1, "R6 write redirect", k);
    xlate(32'h1234_5001, 1, "R6 no redirect", k);
    cfg_scratch_en = 0;

    for (int i = 0; i < 256; i++) pt[20'h40000 + 20'(i)] = F_SP | F_VLD | F_WR | (32'h0A00 + 32'(i));
    xlate(32'h4001_2345, 0, "R3 superpage", k);
    xlate(32'h400F_F001, 1, "R3 same megabyte", k);

    pulse_clear();
    repeat (3) @(negedge clk);
    pulse_clear();
    repeat (8) @(negedge clk);
    xlate(32'h1234_5000, 0, "R9 after clear", k);

    for (int p = 0; p < 9; p++) pt[20'h50000 + 20'(p)] = F_VLD | F_WR | (32'h1000 + 32'(p));
    pulse_clear();
    for (int p = 0; p < 9; p++) xlate(32'h5000_0000 + 32'(p) * 32'h1000, 0, "R8 fill", k);
    xlate(32'h5000_0000, 0, "R8 evicted", k);
    xlate(32'h5000_2000, 0, "R8 kept", k);
    xlate(32'h5000_1000, 0, "R8 second evict", k);

    pulse_clear();
    xlate(32'h5000_3000, 0, "R10 stall", k);
    check("R10 waited for clear", 64'(k >= 8), 64'd1);

    lat = 6;
    f = fetches;
    fork
      xlate(32'h5000_4000, 0, "R10 fill during clear", k);
      begin
        wait (fetches == f + 1);
        @(negedge clk);
        pulse_clear();
      end
    join
    lat = 2;
    repeat (10) @(negedge clk);
    xlate(32'h5000_4000, 0, "R10 not cached", k);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule